// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two event counters, each `CW` bits wide, behind a small register interface. Each counter picks its event through a type code. It can count a cycle strobe from the surrounding logic, count software increments, or count nothing. The odd counter has one extra code, chain. With chain selected, the odd counter advances once each time the even counter wraps, so the pair forms a single counter of twice the width.

All register access is a single-cycle write strobe and a combinational read port. No data stream crosses the block's edge, so it has no valid/ready handshake. Every pin is a plain control or status signal.

A counter advances only while its own enable bit and the global enable are both set. The enable-set register can only turn bits on. When a counter wraps, it raises a sticky bit in a status register, and software clears that bit by writing 1 to it. The exception is a chained pair. There the low counter's wrap becomes the carry into the high counter and raises no status. Only a wrap of the high counter raises a status bit.

Top module: `chain_ctr_pair`

## Requirements
- R1: After reset, every readable register reads zero: both counters, both type registers, the enable mask, the overflow status and the global-enable control.
- R2: The address map is 0 counter 0, 1 counter 1, 2 counter 0 type, 3 counter 1 type, 4 enable set, 5 overflow status, 6 software increment and 7 control, where bit 0 of control is the global enable. A counter advances only while its bit in the enable mask (bit i for counter i) and the global enable are both 1. Writing the enable-set register ORs the written bits 1:0 into the mask, so writing 0x3 enables both counters and a 0 bit has no effect.
- R3: A write to a counter address loads the written value on the next clock edge. In that cycle, the load wins over any increment of the same counter.
- R4: Type code 0x011 counts cycles on which the strobe `cyc_evt` is high. Type code 0x000 counts software increments: writing address 6 with bit i set advances counter i once. Any other code counts nothing.
- R5: While counter 1 has type 0x01E (chain), counter 1 advances by exactly one on the same clock edge at which counter 0 wraps from all-ones to zero. This requires counter 1's enable bit and the global enable.
- R6: A wrap of counter 0 sets overflow status bit 0 only when counter 1 is not chained. While chained, the status stays 0 as long as counter 1 does not wrap.
- R7: A wrap of counter 1 sets overflow status bit 1. A chained carry into an all-ones counter 1 gives counter 1 = 0 and status 0x2.
- R8: Writing the overflow status register clears each bit written as 1 and leaves bits written as 0 unchanged. If a wrap sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: With counter 0 of type 0x000 preloaded to 16 below its wrap point and counter 1 chained, 100 software increments leave counter 0 at 84 and advance counter 1 by one.
- R10: Code 0x01E on counter 0 does not chain it to anything, and counter 0 then counts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_evt | input | 1 | Cycle event strobe, one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register write address |
| bus_wdata | input | CW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CW | Read data for `rd_addr`, combinational |

## Verification
The assertions check several behaviours on every cycle:
- a chained carry adds exactly one to the high counter;
- a chained low wrap never raises status bit 0;
- a high wrap always raises bit 1;
- a load lands exactly;
- a counter holds still when the global enable is low.

Only the bench's scenarios can show the rest. These cover the arithmetic of many preload and event-count combinations in both chained and unchained modes, the 100-increment software case ending at 84, the set-wins rule of the status clear, the enable-set OR semantics, and that unused or misplaced type codes count nothing.

// File: rtl/chain_ctr_pkg.sv
package chain_ctr_pkg;
  localparam int unsigned NCTR = 2;
  localparam int unsigned EVW  = 10;
  localparam int unsigned AW   = 3;

  typedef enum logic [AW-1:0] {
    A_CNT0  = 3'd0,
    A_CNT1  = 3'd1,
    A_TYPE0 = 3'd2,
    A_TYPE1 = 3'd3,
    A_ENSET = 3'd4,
    A_OVF   = 3'd5,
    A_SWINC = 3'd6,
    A_CTRL  = 3'd7
  } reg_addr_e;

  localparam logic [EVW-1:0] EV_SWINC  = 10'h000;
  localparam logic [EVW-1:0] EV_CYCLES = 10'h011;
  localparam logic [EVW-1:0] EV_CHAIN  = 10'h01E;
endpackage

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          inc,
  output logic [CW-1:0] val,
  output logic          wrap
);
  logic [CW-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + CW'(1);
  end

  assign val  = q;
  // a wrap only happens when the increment is actually taken
  assign wrap = inc & ~ld & (&q);
endmodule

// File: rtl/evt_select.sv
module evt_select
  import chain_ctr_pkg::*;
#(
  parameter bit CAN_CHAIN = 1'b0
) (
  input  logic [EVW-1:0] ev_type,
  input  logic           cyc_evt,
  input  logic           sw_hit,
  input  logic           carry_in,
  output logic           req,
  output logic           chained
);
  generate
    if (CAN_CHAIN) begin : g_chain
      assign chained = (ev_type == EV_CHAIN);
    end else begin : g_nochain
      assign chained = 1'b0;
    end
  endgenerate

  always_comb begin
    if (chained) req = carry_in;
    else req = ((ev_type == EV_CYCLES) & cyc_evt) |
               ((ev_type == EV_SWINC) & sw_hit);
  end
endmodule

// File: rtl/ovf_status.sv
module ovf_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] st;
  logic [N-1:0] clr;

  assign clr = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | set;
  end

  assign status = st;
endmodule

// File: rtl/chain_ctr_pair.sv
module chain_ctr_pair
  import chain_ctr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_evt,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [NCTR-1:0][CW-1:0]  cnt_val;
  logic [NCTR-1:0][EVW-1:0] ev_type_q;
  logic [NCTR-1:0]          en_mask;
  logic                     glob_en;
  logic [NCTR-1:0]          ld;
  logic [NCTR-1:0]          inc;
  logic [NCTR-1:0]          req;
  logic [NCTR-1:0]          wrap;
  logic [NCTR-1:0]          sw_hit;
  logic [NCTR-1:0]          ovf_set;
  logic [NCTR-1:0]          ovf_q;
  logic [NCTR:0]            chn;
  logic [NCTR:0]            carry;

  assign chn[NCTR] = 1'b0;
  assign carry[0]  = 1'b0;

  generate
    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
      localparam logic [2:0] ADR_CNT  = 3'(int'(A_CNT0) + i);
      localparam logic [2:0] ADR_TYPE = 3'(int'(A_TYPE0) + i);

      always_ff @(posedge clk) begin
        if (!rst_n) ev_type_q[i] <= '0;
        else if (bus_we && bus_addr == ADR_TYPE) ev_type_q[i] <= bus_wdata[EVW-1:0];
      end

      assign ld[i]     = bus_we && (bus_addr == ADR_CNT);
      assign sw_hit[i] = bus_we && (bus_addr == A_SWINC) && bus_wdata[i];

      evt_select #(.CAN_CHAIN((i % 2) == 1)) u_sel (
        .ev_type (ev_type_q[i]),
        .cyc_evt (cyc_evt),
        .sw_hit  (sw_hit[i]),
        .carry_in(carry[i]),
        .req     (req[i]),
        .chained (chn[i])
      );

      assign inc[i] = glob_en & en_mask[i] & req[i];

      ctr_slice #(.CW(CW)) u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld[i]),
        .ld_val(bus_wdata),
        .inc   (inc[i]),
        .val   (cnt_val[i]),
        .wrap  (wrap[i])
      );

      // even counters hand their wrap to the next odd counter
      assign carry[i+1]  = ((i % 2) == 0) ? wrap[i] : 1'b0;
      assign ovf_set[i]  = wrap[i] & ~(((i % 2) == 0) & chn[i+1]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0;
      glob_en <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_ENSET) en_mask <= en_mask | bus_wdata[NCTR-1:0];
      if (bus_addr == A_CTRL)  glob_en <= bus_wdata[0];
    end
  end

  ovf_status #(.N(NCTR)) u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (ovf_set),
    .clr_we  (bus_we && (bus_addr == A_OVF)),
    .clr_mask(bus_wdata[NCTR-1:0]),
    .status  (ovf_q)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CNT0:  rd_data = cnt_val[0];
      A_CNT1:  rd_data = cnt_val[1];
      A_TYPE0: rd_data = CW'(ev_type_q[0]);
      A_TYPE1: rd_data = CW'(ev_type_q[1]);
      A_ENSET: rd_data = CW'(en_mask);
      A_OVF:   rd_data = CW'(ovf_q);
      A_CTRL:  rd_data = CW'(glob_en);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/chain_ctr_pair_chk.sv
module chain_ctr_pair_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glob_en,
  input logic [1:0]    en_mask,
  input logic [1:0]    ld,
  input logic [1:0]    wrap,
  input logic          chain1,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] ld_val,
  input logic [1:0]    ovf
);
  assert_chain_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chain1 && wrap[0] && glob_en && en_mask[1] && !ld[1]) |=> cnt1 == $past(cnt1) + CW'(1));

  assert_no_low_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain1 && wrap[0] && !ovf[0]) |=> !ovf[0]);

  assert_high_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> ovf[1]);

  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !ld[0]) |=> $stable(cnt0));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld[0] |=> cnt0 == $past(ld_val));
endmodule

bind chain_ctr_pair chain_ctr_pair_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .glob_en(glob_en),
  .en_mask(en_mask),
  .ld     (ld),
  .wrap   (wrap),
  .chain1 (chn[1]),
  .cnt0   (cnt_val[0]),
  .cnt1   (cnt_val[1]),
  .ld_val (bus_wdata),
  .ovf    (ovf_q)
);

// File: tb/sim_chain_ctr_pair.sv
module sim_chain_ctr_pair;
  localparam int CW = 32;
  localparam logic [CW-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_evt = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  chain_ctr_pair #(.CW(CW)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input int n);
    if (n > 0) begin
      @(negedge clk);
      cyc_evt = 1'b1;
      repeat (n) @(negedge clk);
      cyc_evt = 1'b0;
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    logic [CW-1:0] v;
    logic [2*CW-1:0] tot, t1;
    logic [CW-1:0] s0, s1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk($sformatf("R1 reset addr %0d", a), v, '0);
    end

    // R2 enable gating
    wr(3'd2, 32'h011);
    wr(3'd7, 32'h1);
    pulse(5);
    rd(3'd0, v); chk("R2 disabled counter holds", v, 32'd0);
    wr(3'd4, 32'h1);
    pulse(5);
    rd(3'd0, v); chk("R2 R4 cycle count", v, 32'd5);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R2 enable-set zero no effect", v, 32'h1);
    wr(3'd4, 32'h3);
    rd(3'd4, v); chk("R2 enable both", v, 32'h3);
    wr(3'd7, 32'h0);
    pulse(3);
    rd(3'd0, v); chk("R2 global off holds", v, 32'd5);
    wr(3'd7, 32'h1);

    // R3 load beats increment
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h1234; cyc_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; cyc_evt = 1'b0;
    rd(3'd0, v); chk("R3 load priority", v, 32'h1234);

    // chained sweep: R5 R6 R7
    wr(3'd3, 32'h01E);
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n < 10; n++) begin
        for (int h = 0; h < 2; h++) begin
          s0 = ALL - CW'(k);
          s1 = (h == 1) ? ALL : CW'(k);
          wr(3'd5, 32'h3);
          wr(3'd0, s0);
          wr(3'd1, s1);
          pulse(n);
          tot = {{CW{1'b0}}, s0} + 64'(n);
          t1  = {{CW{1'b0}}, s1} + 64'(tot[2*CW-1:CW]);
          rd(3'd0, v); chk($sformatf("R5 chained c0 k=%0d n=%0d", k, n), v, tot[CW-1:0]);
          rd(3'd1, v); chk($sformatf("R5 chained c1 k=%0d n=%0d h=%0d", k, n, h), v, t1[CW-1:0]);
          rd(3'd5, v); chk($sformatf("R6 R7 chained ovf k=%0d n=%0d h=%0d", k, n, h), v,
                           (t1[2*CW-1:CW] != 0) ? 32'h2 : 32'h0);
        end
      end
    end

    // unchained sweep: R6
    wr(3'd3, 32'h000);
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n < 10; n++) begin
        s0 = ALL - CW'(k);
        wr(3'd5, 32'h3);
        wr(3'd0, s0);
        wr(3'd1, 32'h77);
        pulse(n);
        tot = {{CW{1'b0}}, s0} + 64'(n);
        rd(3'd0, v); chk($sformatf("R6 unchained c0 k=%0d n=%0d", k, n), v, tot[CW-1:0]);
        rd(3'd1, v); chk($sformatf("R6 unchained c1 k=%0d n=%0d", k, n), v, 32'h77);
        rd(3'd5, v); chk($sformatf("R6 unchained ovf k=%0d n=%0d", k, n), v,
                         (tot[2*CW-1:CW] != 0) ? 32'h1 : 32'h0);
      end
    end

    // R8 write-one-to-clear and set wins
    wr(3'd3, 32'h011);
    wr(3'd5, 32'h3);
    wr(3'd0, ALL);
    wr(3'd1, ALL);
    pulse(1);
    rd(3'd5, v); chk("R7 R6 both wrap ovf", v, 32'h3);
    wr(3'd5, 32'h2);
    rd(3'd5, v); chk("R8 clear bit1 only", v, 32'h1);
    wr(3'd0, ALL);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1; cyc_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; cyc_evt = 1'b0;
    rd(3'd5, v); chk("R8 set wins over clear", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R8 clear bit0", v, 32'h0);

    // R9 software increments chained
    wr(3'd2, 32'h000);
    wr(3'd3, 32'h01E);
    wr(3'd0, 32'hFFFF_FFF0);
    wr(3'd1, 32'h0);
    for (int i = 0; i < 100; i++) wr(3'd6, 32'h1);
    rd(3'd0, v); chk("R9 c0 after 100 sw incr", v, 32'd84);
    rd(3'd1, v); chk("R9 c1 after 100 sw incr", v, 32'd1);
    rd(3'd5, v); chk("R9 R6 no ovf", v, 32'h0);
    wr(3'd0, 32'hFFFF_FFF0);
    wr(3'd1, ALL);
    for (int i = 0; i < 100; i++) wr(3'd6, 32'h1);
    rd(3'd0, v); chk("R9 c0 second run", v, 32'd84);
    rd(3'd1, v); chk("R7 c1 wraps to zero", v, 32'd0);
    rd(3'd5, v); chk("R7 ovf 0x2", v, 32'h2);
    rd(3'd6, v); chk("R2 swinc reads zero", v, 32'h0);

    // R4 software increment on counter 1 only
    wr(3'd3, 32'h000);
    wr(3'd0, 32'h40);
    wr(3'd1, 32'h5);
    wr(3'd6, 32'h2);
    rd(3'd1, v); chk("R4 sw incr bit1", v, 32'h6);
    rd(3'd0, v); chk("R4 c0 untouched by bit1", v, 32'h40);
    wr(3'd3, 32'h055);
    pulse(4);
    wr(3'd6, 32'h2);
    rd(3'd1, v); chk("R4 unknown code counts nothing", v, 32'h6);

    // R10 chain code on counter 0
    wr(3'd2, 32'h01E);
    pulse(6);
    wr(3'd6, 32'h1);
    rd(3'd0, v); chk("R10 chain code on c0 counts nothing", v, 32'h40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule